// File: doc/BRIEF.md
# Retriggerable Digital One-Shot

This block is a clocked stand-in for a resistor-capacitor timed, retriggerable monostable. It watches three asynchronous control inputs: a falling-edge trigger, a rising-edge trigger, and an active-low clear whose release can also fire. It drives a single pulse output. Each input passes through a two-flop synchronizer before its edges are detected, and the trigger conditions are judged on the synchronized levels of a single cycle.

Each accepted trigger starts a pulse with two parts. The first is a fixed "discharge" phase of `DISCHARGE_CYCLES` clocks. The second is a "charge" phase whose length in clocks comes from `widthIn`, which is sampled at the moment the trigger is accepted. The output stays high across both phases. A trigger during the charge phase restarts the discharge phase, so the pulse is stretched with no gap. A trigger during the discharge phase is ignored. Holding clear low stops any pulse and keeps the block idle.

Top module: `oneshot_top`

## Requirements
- R1: After the synchronous reset (`rstN` low), `pulseOut` is low and stays low while no trigger is applied.
- R2: A rising edge on `trigRiseIn` while `trigFallIn` is low starts a pulse. `pulseOut` is then high for exactly `DISCHARGE_CYCLES + widthIn` cycles.
- R3: A falling edge on `trigFallIn` while `trigRiseIn` is high starts a pulse of the same length as in R2.
- R4: A rising edge on `clearN` while `trigFallIn` is low and `trigRiseIn` is high starts a pulse of the same length as in R2.
- R5: A `trigRiseIn` edge while `trigFallIn` is high, or a `trigFallIn` edge while `trigRiseIn` is low, produces no pulse.
- R6: While `clearN` is low, `pulseOut` is low within three clock edges and every trigger is ignored. After `clearN` rises, the next pulse has its full length.
- R7: A trigger accepted during the charge phase keeps `pulseOut` high without a gap. The pulse then ends `DISCHARGE_CYCLES + widthIn` cycles after that acceptance, using the `widthIn` value sampled at the retrigger.
- R8: A trigger that arrives during the discharge phase has no effect, and the pulse ends at its original time.
- R9: A `widthIn` of zero gives a charge phase of one cycle, so the pulse lasts `DISCHARGE_CYCLES + 1` cycles.
- R10: Changes to `widthIn` after a trigger has been accepted do not change the length of that pulse.
- R11: `pulseOut` rises on the third rising clock edge after the trigger input changes: two edges for synchronization and one for the state register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| trigFallIn | input | 1 | Asynchronous trigger; fires on its falling edge |
| trigRiseIn | input | 1 | Asynchronous trigger; fires on its rising edge |
| clearN | input | 1 | Asynchronous active-low clear; its rising edge can fire a trigger |
| widthIn | input | WIDTH_BITS | Charge-phase length in cycles, sampled when a trigger is accepted |
| pulseOut | output | 1 | One-shot output |

## Verification
The hardest cases to reach from the ports are the two retrigger windows. A second trigger must reach the state machine exactly while it is in the discharge phase, or exactly while it is in the charge phase. Each such trigger needs a full low-then-high cycle of the rising-edge input, and it is seen three clocks late through the synchronizer. The bench counts rising clock edges from the first trigger and schedules the second input toggle so that its synchronized edge arrives in the chosen phase. It then checks from the pulse's total length whether the restart took effect. The clear-release trigger also needs careful ordering: the other inputs are set while clear holds the block idle, so that no earlier edge fires.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_DISCHARGE = 2'd1,
    ST_CHARGE    = 2'd2
  } phase_e;

  // Strobes from control to the timing datapath
  typedef struct packed {
    logic loadDis;    // load discharge count, capture width
    logic loadChg;    // load charge count from captured width
    logic countDown;  // decrement the running count
    logic wipe;       // clear count and captured width
  } timerCmd_t;

endpackage

// File: rtl/oneshot_insync.sv
module oneshot_insync #(
  parameter int unsigned NUM_IN = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [NUM_IN-1:0] IDLE_LEVEL = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_IN-1:0] rawIn,
  output logic [NUM_IN-1:0] level,
  output logic [NUM_IN-1:0] prevLevel,
  output logic              armed
);

  localparam int unsigned ARM_LIMIT = STAGES + 1;
  localparam int unsigned ARM_W     = $clog2(ARM_LIMIT + 1);

  for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_chain
    logic [STAGES-1:0] chain;
    logic              lastLvl;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        chain   <= {STAGES{IDLE_LEVEL[gi]}};
        lastLvl <= IDLE_LEVEL[gi];
      end else begin
        chain   <= {chain[STAGES-2:0], rawIn[gi]};
        lastLvl <= chain[STAGES-1];
      end
    end

    assign level[gi]     = chain[STAGES-1];
    assign prevLevel[gi] = lastLvl;
  end

  // Edges are masked until every chain holds real samples
  logic [ARM_W-1:0] armCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armCnt <= '0;
    end else if (armCnt != ARM_W'(ARM_LIMIT)) begin
      armCnt <= armCnt + 1'b1;
    end
  end

  assign armed = (armCnt == ARM_W'(ARM_LIMIT));

endmodule

// File: rtl/oneshot_ctrl.sv
module oneshot_ctrl
  import oneshot_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      armed,
  input  logic      fallLvl,
  input  logic      fallPrev,
  input  logic      riseLvl,
  input  logic      risePrev,
  input  logic      clrLvl,
  input  logic      clrPrev,
  input  logic      cntDone,
  output timerCmd_t cmd,
  output logic      trigValid,
  output logic      inDis,
  output logic      inChg,
  output logic      pulse
);

  phase_e state, stateNext;

  logic fallEdge, riseEdge, clrEdge;

  assign fallEdge = fallPrev & ~fallLvl;
  assign riseEdge = riseLvl & ~risePrev;
  assign clrEdge  = clrLvl & ~clrPrev;

  // Three gated trigger conditions on same-cycle synchronized levels
  assign trigValid = armed & clrLvl &
                     ((riseEdge & ~fallLvl) |
                      (fallEdge & riseLvl) |
                      (clrEdge & ~fallLvl & riseLvl));

  always_comb begin
    stateNext = state;
    cmd       = '0;
    if (!clrLvl) begin
      stateNext = ST_IDLE;
      cmd.wipe  = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (trigValid) begin
            stateNext   = ST_DISCHARGE;
            cmd.loadDis = 1'b1;
          end
        end
        ST_DISCHARGE: begin
          if (cntDone) begin
            stateNext   = ST_CHARGE;
            cmd.loadChg = 1'b1;
          end else begin
            cmd.countDown = 1'b1;
          end
        end
        ST_CHARGE: begin
          if (trigValid) begin
            stateNext   = ST_DISCHARGE;
            cmd.loadDis = 1'b1;
          end else if (cntDone) begin
            stateNext = ST_IDLE;
          end else begin
            cmd.countDown = 1'b1;
          end
        end
        default: begin
          stateNext = ST_IDLE;
          cmd.wipe  = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      state <= stateNext;
    end
  end

  assign inDis = (state == ST_DISCHARGE);
  assign inChg = (state == ST_CHARGE);
  assign pulse = inDis | inChg;

endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer
  import oneshot_pkg::*;
#(
  parameter int unsigned WIDTH_BITS       = 8,
  parameter int unsigned DISCHARGE_CYCLES = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  timerCmd_t             cmd,
  input  logic [WIDTH_BITS-1:0] widthIn,
  output logic                  cntDone,
  output logic [WIDTH_BITS > $clog2(DISCHARGE_CYCLES+1) ? WIDTH_BITS-1 : $clog2(DISCHARGE_CYCLES+1)-1 : 0] cnt
);

  localparam int unsigned DIS_W = $clog2(DISCHARGE_CYCLES + 1);
  localparam int unsigned CNT_W = (WIDTH_BITS > DIS_W) ? WIDTH_BITS : DIS_W;
  localparam logic [CNT_W-1:0] DIS_LOAD = CNT_W'(DISCHARGE_CYCLES - 1);

  logic [WIDTH_BITS-1:0] widthHeld;
  logic [CNT_W-1:0]      chgLoad;

  // Zero width is stretched to a single charge cycle
  assign chgLoad = (widthHeld == '0) ? '0 : (CNT_W'(widthHeld) - 1'b1);

  always_ff @(posedge clk) begin
    if (!rstN || cmd.wipe) begin
      cnt       <= '0;
      widthHeld <= '0;
    end else if (cmd.loadDis) begin
      cnt       <= DIS_LOAD;
      widthHeld <= widthIn;
    end else if (cmd.loadChg) begin
      cnt <= chgLoad;
    end else if (cmd.countDown) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign cntDone = (cnt == '0);

endmodule

// File: rtl/oneshot_top.sv
module oneshot_top
  import oneshot_pkg::*;
#(
  parameter int unsigned WIDTH_BITS       = 8,
  parameter int unsigned DISCHARGE_CYCLES = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  trigFallIn,
  input  logic                  trigRiseIn,
  input  logic                  clearN,
  input  logic [WIDTH_BITS-1:0] widthIn,
  output logic                  pulseOut
);

  localparam int unsigned DIS_W = $clog2(DISCHARGE_CYCLES + 1);
  localparam int unsigned CNT_W = (WIDTH_BITS > DIS_W) ? WIDTH_BITS : DIS_W;

  // Bit order: 0 = falling trigger, 1 = rising trigger, 2 = clear
  logic [2:0] lvl, prv;
  logic       armed;
  timerCmd_t  cmd;
  logic       trigValid, inDis, inChg, cntDone, clrLevel;
  logic [CNT_W-1:0] cnt;

  oneshot_insync #(
    .NUM_IN    (3),
    .STAGES    (2),
    .IDLE_LEVEL(3'b101)
  ) sync_i (
    .clk      (clk),
    .rstN     (rstN),
    .rawIn    ({clearN, trigRiseIn, trigFallIn}),
    .level    (lvl),
    .prevLevel(prv),
    .armed    (armed)
  );

  assign clrLevel = lvl[2];

  oneshot_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .armed    (armed),
    .fallLvl  (lvl[0]),
    .fallPrev (prv[0]),
    .riseLvl  (lvl[1]),
    .risePrev (prv[1]),
    .clrLvl   (clrLevel),
    .clrPrev  (prv[2]),
    .cntDone  (cntDone),
    .cmd      (cmd),
    .trigValid(trigValid),
    .inDis    (inDis),
    .inChg    (inChg),
    .pulse    (pulseOut)
  );

  oneshot_timer #(
    .WIDTH_BITS      (WIDTH_BITS),
    .DISCHARGE_CYCLES(DISCHARGE_CYCLES)
  ) timer_i (
    .clk    (clk),
    .rstN   (rstN),
    .cmd    (cmd),
    .widthIn(widthIn),
    .cntDone(cntDone),
    .cnt    (cnt)
  );

endmodule

// File: rtl/oneshot_chk.sv
module oneshot_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             pulseOut,
  input logic             clrLevel,
  input logic             trigValid,
  input logic             inDis,
  input logic             inChg,
  input logic             cntDone,
  input logic [CNT_W-1:0] cnt
);

  // R2
  rise_needs_trigger_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pulseOut) |-> $past(trigValid));

  // R6
  clear_forces_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !clrLevel |=> !pulseOut);

  // R7
  retrig_no_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pulseOut && trigValid && clrLevel) |=> pulseOut);

  // R8
  discharge_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inDis && !cntDone && clrLevel) |=> (inDis && (cnt == $past(cnt) - 1'b1)));

  // R9
  charge_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inDis && cntDone && clrLevel) |=> (inChg && pulseOut));

  // R1
  fall_has_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pulseOut) |-> ($past(!clrLevel) || $past(inChg && cntDone)));

endmodule

bind oneshot_top oneshot_chk #(.CNT_W(CNT_W)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .pulseOut (pulseOut),
  .clrLevel (clrLevel),
  .trigValid(trigValid),
  .inDis    (inDis),
  .inChg    (inChg),
  .cntDone  (cntDone),
  .cnt      (cnt)
);

// File: tb/oneshot_top_tb.sv
module oneshot_top_tb_top;

  localparam int WB = 8;
  localparam int DC = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          trigFallIn = 1'b1;
  logic          trigRiseIn = 1'b0;
  logic          clearN = 1'b1;
  logic [WB-1:0] widthIn = '0;
  logic          pulseOut;

  int posCnt = 0;
  int riseCount = 0, fallCount = 0, riseAt = 0, fallAt = 0;
  bit lastQ = 1'b0;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  oneshot_top #(.WIDTH_BITS(WB), .DISCHARGE_CYCLES(DC)) dut_i (
    .clk(clk), .rstN(rstN), .trigFallIn(trigFallIn), .trigRiseIn(trigRiseIn),
    .clearN(clearN), .widthIn(widthIn), .pulseOut(pulseOut)
  );

  always @(posedge clk) posCnt <= posCnt + 1;

  always @(negedge clk) begin
    if (pulseOut && !lastQ) begin riseCount++; riseAt = posCnt; end
    if (!pulseOut && lastQ) begin fallCount++; fallAt = posCnt; end
    lastQ = pulseOut;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic waitUntil(input int t);
    while (posCnt < t) @(negedge clk);
  endtask

  task automatic testReset();
    int r0;
    r0 = riseCount;
    check(pulseOut == 1'b0, "R1", "pulse after reset", pulseOut, 0);
    waitCyc(12);
    check(riseCount == r0, "R1", "rises while idle", riseCount - r0, 0);
  endtask

  // rising-edge trigger with the falling input held low
  task automatic testRiseTrig(input int w, input string req);
    int t0, r0;
    trigFallIn = 1'b0; widthIn = WB'(w);
    waitCyc(5);
    r0 = riseCount; t0 = posCnt;
    trigRiseIn = 1'b1;
    waitCyc(DC + w + 8);
    check(riseCount == r0 + 1, req, "pulse count", riseCount - r0, 1);
    check(riseAt - t0 == 3, "R11", "rise latency", riseAt - t0, 3);
    check(fallAt - riseAt == DC + ((w == 0) ? 1 : w), req, "pulse length",
          fallAt - riseAt, DC + ((w == 0) ? 1 : w));
    trigRiseIn = 1'b0; waitCyc(4);
    trigFallIn = 1'b1; waitCyc(4);
  endtask

  task automatic testFallTrig();
    int t0, r0;
    widthIn = 8'd6;
    trigRiseIn = 1'b0; trigFallIn = 1'b1; waitCyc(3);
    trigRiseIn = 1'b1; trigFallIn = 1'b1; waitCyc(4);  // rise with A high: inhibited
    r0 = riseCount; t0 = posCnt;
    trigFallIn = 1'b0;
    waitCyc(DC + 14);
    check(riseCount == r0 + 1, "R3", "pulse count", riseCount - r0, 1);
    check(fallAt - riseAt == DC + 6, "R3", "pulse length", fallAt - riseAt, DC + 6);
    check(riseAt - t0 == 3, "R11", "rise latency", riseAt - t0, 3);
    trigFallIn = 1'b1; waitCyc(3);
    trigRiseIn = 1'b0; waitCyc(4);
  endtask

  task automatic testInhibit();
    int r0;
    r0 = riseCount;
    trigFallIn = 1'b1; trigRiseIn = 1'b1; waitCyc(4);  // rise with A high
    trigRiseIn = 1'b0; waitCyc(4);
    trigFallIn = 1'b0; waitCyc(4);                    // fall with B low
    trigFallIn = 1'b1; waitCyc(6);
    check(riseCount == r0, "R5", "inhibited edges", riseCount - r0, 0);
    check(pulseOut == 1'b0, "R5", "output level", pulseOut, 0);
  endtask

  task automatic testClearTrig();
    int t0, r0;
    widthIn = 8'd4;
    clearN = 1'b0; waitCyc(3);
    r0 = riseCount;
    trigFallIn = 1'b0; waitCyc(3);
    trigRiseIn = 1'b1; waitCyc(8);   // valid-looking edge during clear
    check(riseCount == r0, "R6", "trigger during clear", riseCount - r0, 0);
    t0 = posCnt;
    clearN = 1'b1;
    waitCyc(DC + 12);
    check(riseCount == r0 + 1, "R4", "clear release pulse", riseCount - r0, 1);
    check(riseAt - t0 == 3, "R4", "rise latency", riseAt - t0, 3);
    check(fallAt - riseAt == DC + 4, "R4", "pulse length", fallAt - riseAt, DC + 4);
    trigRiseIn = 1'b0; waitCyc(3);
    trigFallIn = 1'b1; waitCyc(4);
  endtask

  task automatic testClearMid();
    int t0, t1, r0;
    widthIn = 8'd20;
    trigFallIn = 1'b0; waitCyc(4);
    t0 = posCnt;
    trigRiseIn = 1'b1;
    waitUntil(t0 + 9);
    t1 = posCnt;
    clearN = 1'b0;
    waitCyc(6);
    check(fallAt - t1 == 3, "R6", "clear to low", fallAt - t1, 3);
    check(pulseOut == 1'b0, "R6", "held low", pulseOut, 0);
    trigRiseIn = 1'b0; waitCyc(4);
    r0 = riseCount;
    clearN = 1'b1; waitCyc(6);   // release with B low: no trigger
    check(riseCount == r0, "R6", "release with B low", riseCount - r0, 0);
    widthIn = 8'd5;
    t0 = posCnt;
    trigRiseIn = 1'b1;
    waitCyc(DC + 12);
    check(fallAt - riseAt == DC + 5, "R6", "full pulse after clear", fallAt - riseAt, DC + 5);
    trigRiseIn = 1'b0; waitCyc(3);
    trigFallIn = 1'b1; waitCyc(4);
  endtask

  task automatic testRetrigCharge();
    int t0, r0;
    widthIn = 8'd10;
    trigFallIn = 1'b0; waitCyc(4);
    r0 = riseCount; t0 = posCnt;
    trigRiseIn = 1'b1;
    waitCyc(1); trigRiseIn = 1'b0;
    waitUntil(t0 + 8);
    widthIn = 8'd5;
    trigRiseIn = 1'b1;           // accepted at t0+11, in charge phase
    waitCyc(20);
    check(riseCount == r0 + 1, "R7", "single pulse", riseCount - r0, 1);
    check(fallAt - riseAt == 8 + DC + 5, "R7", "stretched length",
          fallAt - riseAt, 8 + DC + 5);
    trigRiseIn = 1'b0; waitCyc(3);
    trigFallIn = 1'b1; waitCyc(4);
  endtask

  task automatic testRetrigDischarge();
    int t0, r0;
    widthIn = 8'd6;
    trigFallIn = 1'b0; waitCyc(4);
    r0 = riseCount; t0 = posCnt;
    trigRiseIn = 1'b1;
    waitCyc(1); trigRiseIn = 1'b0;
    waitCyc(1); trigRiseIn = 1'b1;   // evaluated at t0+5, in discharge phase
    waitCyc(DC + 14);
    check(riseCount == r0 + 1, "R8", "single pulse", riseCount - r0, 1);
    check(fallAt - riseAt == DC + 6, "R8", "unchanged length", fallAt - riseAt, DC + 6);
    trigRiseIn = 1'b0; waitCyc(3);
    trigFallIn = 1'b1; waitCyc(4);
  endtask

  task automatic testWidthHold();
    int r0;
    widthIn = 8'd7;
    trigFallIn = 1'b0; waitCyc(4);
    r0 = riseCount;
    trigRiseIn = 1'b1;
    waitCyc(5);
    widthIn = 8'd30;
    waitCyc(DC + 14);
    check(fallAt - riseAt == DC + 7, "R10", "width after accept", fallAt - riseAt, DC + 7);
    check(riseCount == r0 + 1, "R10", "pulse count", riseCount - r0, 1);
    trigRiseIn = 1'b0; waitCyc(3);
    trigFallIn = 1'b1; waitCyc(4);
  endtask

  initial begin
    waitCyc(4);
    rstN = 1'b1;
    waitCyc(1);
    testReset();
    testRiseTrig(5, "R2");
    testRiseTrig(1, "R2");
    testRiseTrig(0, "R9");
    testFallTrig();
    testInhibit();
    testClearTrig();
    testClearMid();
    testRetrigCharge();
    testRetrigDischarge();
    testWidthHold();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule